// File: doc/BRIEF.md
# AC97 Slot Router with Buffer-Level Interrupt Request

This block sits between six audio stream buffers and the time slots of an AC97 serial frame. Three streams run towards the codec (playback) and three run away from it (capture). The frame side is presented in parallel: one tag word plus twelve 20-bit data slots in each direction, with a single-cycle frame strobe that marks the moment one frame is exchanged. On each strobe the block takes one sample from every enabled, non-empty playback buffer and places it in the slots that stream owns. It also lifts the capture samples out of the incoming slots that are tagged valid and pushes them into their capture buffers.

Stream pairings are fixed. A 32-bit stereo pair is split across slots 3 and 4, a 16-bit mono pair uses slot 5, and a third 16-bit pair uses slot 6 or slot 11. A separate run-time select bit picks that slot for each direction. Every buffer keeps two sticky flags. The level flag marks that the fill count has moved onto the half-way point or onto full. The extreme flag marks that the count has moved onto empty or onto full. An interrupt request output is the OR of the level flags that software has enabled.

Slot n (1 to 12) occupies `in_slots`/`out_slots` bits [(n-1)*20 +: 20]. Its valid bit in the tag word is bit 15-n. Tag bit 15 is the frame-valid bit. Stream numbers 0 to 5 also index every 6-bit flag, enable and clear vector. Even numbers are playback and odd numbers are capture.

Top module: `ac97_slot_router`

## Requirements
- R1: Playback stream 0 sends word bits [31:16] in slot 3 and bits [15:0] in slot 4. Each half sits in slot bits [19:4] with bits [3:0] zero, and tag bits 12 and 11 are set.
- R2: Playback stream 2 sends its 16-bit sample in slot 5, in bits [19:4] with bits [3:0] zero, and sets tag bit 10.
- R3: Playback stream 4 uses slot 6 (tag bit 9) when `pb_sel11` is 0 and slot 11 (tag bit 4) when it is 1. The slot that is not selected stays zero.
- R4: A playback slot is valid only when its stream is enabled and its buffer is non-empty, and an invalid slot is all zero. Slots 1, 2, 7 to 10 and 12 and tag bits [3:0] are always zero. Tag bit 15 is the OR of tag bits [14:0].
- R5: `out_tag`/`out_slots` are registered and change only in the cycle after `frame_stb`. Each strobe removes exactly one entry from every playback stream that was valid in that frame.
- R6: Capture stream 1 accepts a word only when it is enabled and tag bits 12 and 11 are both set. The word is {slot3[19:4], slot4[19:4]}.
- R7: Capture stream 3 accepts slot5[19:4] when tag bit 10 is set. Capture stream 5 reads slot 6 (tag bit 9) when `cap_sel11` is 0 and slot 11 (tag bit 4) when it is 1.
- R8: Each buffer holds DEPTH entries. A push into a full buffer is dropped. `pb_full` reports a full playback buffer, `cap_avail` reports a non-empty capture buffer, and the capture read data shows the oldest entry.
- R9: A level flag is set when a buffer's count changes and the new count is DEPTH/2 or DEPTH. `smi` is the OR of `mid_flags & smi_en`.
- R10: An extreme flag is set when a buffer's count changes and the new count is 0 or DEPTH.
- R11: Both flag sets hold until a 1 is written on the matching clear bit. A set event in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stream_en | input | 6 | Per-stream enable |
| pb_sel11 | input | 1 | Playback stream 4 slot: 0 = slot 6, 1 = slot 11 |
| cap_sel11 | input | 1 | Capture stream 5 slot: 0 = slot 6, 1 = slot 11 |
| pb_wr | input | 3 | Write strobes for playback streams 0, 2, 4 |
| pb0_wdata | input | 32 | Stereo word for stream 0 |
| pb1_wdata | input | 16 | Sample for stream 2 |
| pb2_wdata | input | 16 | Sample for stream 4 |
| pb_full | output | 3 | Playback buffer full, streams 0, 2, 4 |
| cap_rd | input | 3 | Read strobes for capture streams 1, 3, 5 |
| cap0_rdata | output | 32 | Oldest word of stream 1 |
| cap1_rdata | output | 16 | Oldest sample of stream 3 |
| cap2_rdata | output | 16 | Oldest sample of stream 5 |
| cap_avail | output | 3 | Capture buffer non-empty, streams 1, 3, 5 |
| frame_stb | input | 1 | Frame exchange strobe |
| in_tag | input | 16 | Incoming tag word |
| in_slots | input | 240 | Incoming slots 1 to 12 |
| out_tag | output | 16 | Outgoing tag word |
| out_slots | output | 240 | Outgoing slots 1 to 12 |
| smi_en | input | 6 | Level-flag interrupt enables |
| clr_mid | input | 6 | Write-1 clear for level flags |
| clr_xtr | input | 6 | Write-1 clear for extreme flags |
| mid_flags | output | 6 | Sticky level flags |
| xtr_flags | output | 6 | Sticky extreme flags |
| smi | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the memory-side write or read of a buffer and the frame strobe that drains or fills the same buffer. The second pair is a flag set event and a software clear of that flag. Random traffic with a one-in-three frame rate, dense write and read strobes and a high clear rate keeps each buffer near its half and full marks, so both collisions occur often. A queue-based reference model predicts the net count change and the flag outcome (set wins over clear, and no event when the count does not move). It is compared with the outputs after every clock.

// File: rtl/ac97_router_pkg.sv
package ac97_router_pkg;
  localparam int NSLOT   = 12;
  localparam int SLOT_W  = 20;
  localparam int TAG_W   = 16;
  localparam int NSTREAM = 6;
  localparam int FRAME_W = NSLOT * SLOT_W;

  // low bit of slot n inside the flattened slot vector
  function automatic int slot_lo(input int n);
    return (n - 1) * SLOT_W;
  endfunction

  // tag valid bit of slot n
  function automatic int tag_pos(input int n);
    return (TAG_W - 1) - n;
  endfunction

  function automatic logic [SLOT_W-1:0] pad16(input logic [15:0] s);
    return {s, 4'h0};
  endfunction
endpackage

// File: rtl/ac97_stream_fifo.sv
module ac97_stream_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty,
  input  logic         clr_mid,
  input  logic         clr_xtr,
  output logic         mid_flag,
  output logic         xtr_flag
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mid_q, mid_d, xtr_q, xtr_d;
  logic          do_push, do_pop, moved;

  always_comb begin
    do_push = push && (cnt_q != CW'(DEPTH));
    do_pop  = pop && (cnt_q != '0);
    wp_d    = do_push ? ((wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1)) : wp_q;
    rp_d    = do_pop  ? ((rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1)) : rp_q;
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
    moved   = (cnt_d != cnt_q);
    mid_d   = (mid_q & ~clr_mid) |
              (moved & ((cnt_d == CW'(HALF)) | (cnt_d == CW'(DEPTH))));
    xtr_d   = (xtr_q & ~clr_xtr) |
              (moved & ((cnt_d == '0) | (cnt_d == CW'(DEPTH))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      mid_q <= 1'b0;
      xtr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      mid_q <= mid_d;
      xtr_q <= xtr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  assign head     = mem[rp_q];
  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign mid_flag = mid_q;
  assign xtr_flag = xtr_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == $past(cnt_q))); // R8
  AST_XTR_ONSET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xtr_flag) |-> (empty || full)); // R10
  AST_MID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_flag && !clr_mid) |=> mid_flag); // R11
  AST_XTR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (xtr_flag && !clr_xtr) |=> xtr_flag); // R11
endmodule

// File: rtl/ac97_frame_pack.sv
module ac97_frame_pack
  import ac97_router_pkg::*;
(
  input  logic [31:0]        stereo_head,
  input  logic [15:0]        mono_head,
  input  logic [15:0]        alt_head,
  input  logic [2:0]         vld,
  input  logic               sel11,
  output logic [TAG_W-1:0]   tag,
  output logic [FRAME_W-1:0] slots
);
  always_comb begin
    tag   = '0;
    slots = '0;
    if (vld[0]) begin
      slots[slot_lo(3) +: SLOT_W] = pad16(stereo_head[31:16]);
      slots[slot_lo(4) +: SLOT_W] = pad16(stereo_head[15:0]);
      tag[tag_pos(3)] = 1'b1;
      tag[tag_pos(4)] = 1'b1;
    end
    if (vld[1]) begin
      slots[slot_lo(5) +: SLOT_W] = pad16(mono_head);
      tag[tag_pos(5)] = 1'b1;
    end
    if (vld[2]) begin
      if (sel11) begin
        slots[slot_lo(11) +: SLOT_W] = pad16(alt_head);
        tag[tag_pos(11)] = 1'b1;
      end else begin
        slots[slot_lo(6) +: SLOT_W] = pad16(alt_head);
        tag[tag_pos(6)] = 1'b1;
      end
    end
    tag[TAG_W-1] = |tag[TAG_W-2:0];
  end
endmodule

// File: rtl/ac97_frame_unpack.sv
module ac97_frame_unpack
  import ac97_router_pkg::*;
(
  input  logic [TAG_W-1:0]   tag,
  input  logic [FRAME_W-1:0] slots,
  input  logic               sel11,
  output logic [2:0]         vld,
  output logic [31:0]        stereo_word,
  output logic [15:0]        mono_word,
  output logic [15:0]        alt_word
);
  always_comb begin
    vld[0]      = tag[tag_pos(3)] & tag[tag_pos(4)];
    stereo_word = {slots[slot_lo(3) + 4 +: 16], slots[slot_lo(4) + 4 +: 16]};
    vld[1]      = tag[tag_pos(5)];
    mono_word   = slots[slot_lo(5) + 4 +: 16];
    if (sel11) begin
      vld[2]   = tag[tag_pos(11)];
      alt_word = slots[slot_lo(11) + 4 +: 16];
    end else begin
      vld[2]   = tag[tag_pos(6)];
      alt_word = slots[slot_lo(6) + 4 +: 16];
    end
  end
endmodule

// File: rtl/ac97_slot_router.sv
module ac97_slot_router
  import ac97_router_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSTREAM-1:0]   stream_en,
  input  logic                 pb_sel11,
  input  logic                 cap_sel11,
  input  logic [2:0]           pb_wr,
  input  logic [31:0]          pb0_wdata,
  input  logic [15:0]          pb1_wdata,
  input  logic [15:0]          pb2_wdata,
  output logic [2:0]           pb_full,
  input  logic [2:0]           cap_rd,
  output logic [31:0]          cap0_rdata,
  output logic [15:0]          cap1_rdata,
  output logic [15:0]          cap2_rdata,
  output logic [2:0]           cap_avail,
  input  logic                 frame_stb,
  input  logic [TAG_W-1:0]     in_tag,
  input  logic [FRAME_W-1:0]   in_slots,
  output logic [TAG_W-1:0]     out_tag,
  output logic [FRAME_W-1:0]   out_slots,
  input  logic [NSTREAM-1:0]   smi_en,
  input  logic [NSTREAM-1:0]   clr_mid,
  input  logic [NSTREAM-1:0]   clr_xtr,
  output logic [NSTREAM-1:0]   mid_flags,
  output logic [NSTREAM-1:0]   xtr_flags,
  output logic                 smi
);
  // reset: asserted asynchronously, released after two clean edges
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic [31:0]        push_d [NSTREAM];
  logic [31:0]        head   [NSTREAM];
  logic [NSTREAM-1:0] push_v, pop_v, empty_v, full_v;
  logic [2:0]         cap_vld, pb_vld;
  logic [31:0]        cap_stereo;
  logic [15:0]        cap_mono, cap_alt;
  logic [TAG_W-1:0]   pk_tag, tag_q, tag_d;
  logic [FRAME_W-1:0] pk_slots, slots_q, slots_d;

  ac97_frame_unpack u_unpack (
    .tag(in_tag), .slots(in_slots), .sel11(cap_sel11),
    .vld(cap_vld), .stereo_word(cap_stereo), .mono_word(cap_mono), .alt_word(cap_alt)
  );

  assign push_d[0] = pb0_wdata;
  assign push_d[1] = cap_stereo;
  assign push_d[2] = {16'h0, pb1_wdata};
  assign push_d[3] = {16'h0, cap_mono};
  assign push_d[4] = {16'h0, pb2_wdata};
  assign push_d[5] = {16'h0, cap_alt};

  for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
    localparam int W = (s < 2) ? 32 : 16;
    localparam int K = s / 2;
    logic [W-1:0] head_w;

    if ((s % 2) == 0) begin : g_play
      assign push_v[s] = pb_wr[K];
      assign pop_v[s]  = frame_stb & stream_en[s];
    end else begin : g_cap
      assign push_v[s] = frame_stb & stream_en[s] & cap_vld[K];
      assign pop_v[s]  = cap_rd[K];
    end

    ac97_stream_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rs_n),
      .push(push_v[s]), .push_data(push_d[s][W-1:0]),
      .pop(pop_v[s]), .head(head_w),
      .full(full_v[s]), .empty(empty_v[s]),
      .clr_mid(clr_mid[s]), .clr_xtr(clr_xtr[s]),
      .mid_flag(mid_flags[s]), .xtr_flag(xtr_flags[s])
    );
    assign head[s] = 32'(head_w);
  end

  assign pb_vld = {stream_en[4] & ~empty_v[4],
                   stream_en[2] & ~empty_v[2],
                   stream_en[0] & ~empty_v[0]};

  ac97_frame_pack u_pack (
    .stereo_head(head[0]), .mono_head(head[2][15:0]), .alt_head(head[4][15:0]),
    .vld(pb_vld), .sel11(pb_sel11), .tag(pk_tag), .slots(pk_slots)
  );

  // outgoing frame register, enabled by the frame strobe
  always_comb begin
    tag_d   = tag_q;
    slots_d = slots_q;
    if (frame_stb) begin
      tag_d   = pk_tag;
      slots_d = pk_slots;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      tag_q   <= '0;
      slots_q <= '0;
    end else begin
      tag_q   <= tag_d;
      slots_q <= slots_d;
    end
  end

  assign out_tag    = tag_q;
  assign out_slots  = slots_q;
  assign pb_full    = {full_v[4], full_v[2], full_v[0]};
  assign cap_avail  = {~empty_v[5], ~empty_v[3], ~empty_v[1]};
  assign cap0_rdata = head[1];
  assign cap1_rdata = head[3][15:0];
  assign cap2_rdata = head[5][15:0];
  assign smi        = |(mid_flags & smi_en);

  AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rs_n)
    !out_tag[tag_pos(5)] |-> (out_slots[slot_lo(5) +: SLOT_W] == '0)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rs_n)
    !$past(frame_stb) |-> $stable(out_tag)); // R5
  AST_ALT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rs_n)
    !(out_tag[tag_pos(6)] && out_tag[tag_pos(11)])); // R3
endmodule

// File: tb/ac97_slot_router_test.sv
module ac97_slot_router_test;
  localparam int DEPTH = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   stream_en = '0, smi_en = '0, clr_mid = '0, clr_xtr = '0;
  logic         pb_sel11 = 1'b0, cap_sel11 = 1'b0, frame_stb = 1'b0;
  logic [2:0]   pb_wr = '0, cap_rd = '0;
  logic [31:0]  pb0_wdata = '0;
  logic [15:0]  pb1_wdata = '0, pb2_wdata = '0;
  logic [15:0]  in_tag = '0;
  logic [239:0] in_slots = '0;
  logic [2:0]   pb_full, cap_avail;
  logic [31:0]  cap0_rdata;
  logic [15:0]  cap1_rdata, cap2_rdata, out_tag;
  logic [239:0] out_slots;
  logic [5:0]   mid_flags, xtr_flags;
  logic         smi;

  always #10 clk = ~clk;

  ac97_slot_router #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .pb_sel11(pb_sel11),
    .cap_sel11(cap_sel11), .pb_wr(pb_wr), .pb0_wdata(pb0_wdata),
    .pb1_wdata(pb1_wdata), .pb2_wdata(pb2_wdata), .pb_full(pb_full),
    .cap_rd(cap_rd), .cap0_rdata(cap0_rdata), .cap1_rdata(cap1_rdata),
    .cap2_rdata(cap2_rdata), .cap_avail(cap_avail), .frame_stb(frame_stb),
    .in_tag(in_tag), .in_slots(in_slots), .out_tag(out_tag), .out_slots(out_slots),
    .smi_en(smi_en), .clr_mid(clr_mid), .clr_xtr(clr_xtr),
    .mid_flags(mid_flags), .xtr_flags(xtr_flags), .smi(smi)
  );

  // reference model state
  logic [31:0]  mq [6][$];
  logic [15:0]  exp_tag = '0;
  logic [239:0] exp_slots = '0;
  logic [5:0]   exp_mid = '0, exp_xtr = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [239:0] act,
                     input logic [239:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lo(input int n);
    return (n - 1) * 20;
  endfunction

  // advance model over one rising edge using the inputs in force
  task automatic tick();
    int old [6];
    int nw;
    logic [15:0]  t;
    logic [239:0] sl;
    logic [31:0]  h, d;
    bit v;
    int n;
    @(posedge clk);
    cycles++;
    for (int s = 0; s < 6; s++) old[s] = mq[s].size();
    if (frame_stb) begin
      t = '0; sl = '0;
      if (stream_en[0] && old[0] > 0) begin
        h = mq[0][0];
        sl[lo(3) +: 20] = {h[31:16], 4'h0};
        sl[lo(4) +: 20] = {h[15:0], 4'h0};
        t[12] = 1'b1; t[11] = 1'b1;
      end
      if (stream_en[2] && old[2] > 0) begin
        h = mq[2][0];
        sl[lo(5) +: 20] = {h[15:0], 4'h0};
        t[10] = 1'b1;
      end
      if (stream_en[4] && old[4] > 0) begin
        h = mq[4][0];
        n = pb_sel11 ? 11 : 6;
        sl[lo(n) +: 20] = {h[15:0], 4'h0};
        t[15 - n] = 1'b1;
      end
      t[15] = |t[14:0];
      exp_tag = t; exp_slots = sl;
    end
    for (int k = 0; k < 3; k++) begin
      int s = 2 * k;
      if (frame_stb && stream_en[s] && old[s] > 0) void'(mq[s].pop_front());
      if (pb_wr[k] && old[s] < DEPTH)
        mq[s].push_back(k == 0 ? pb0_wdata : (k == 1 ? {16'h0, pb1_wdata} : {16'h0, pb2_wdata}));
    end
    for (int k = 0; k < 3; k++) begin
      int s = 2 * k + 1;
      if (k == 0) begin
        v = in_tag[12] && in_tag[11];
        d = {in_slots[lo(3) + 4 +: 16], in_slots[lo(4) + 4 +: 16]};
      end else if (k == 1) begin
        v = in_tag[10];
        d = {16'h0, in_slots[lo(5) + 4 +: 16]};
      end else begin
        n = cap_sel11 ? 11 : 6;
        v = in_tag[15 - n];
        d = {16'h0, in_slots[lo(n) + 4 +: 16]};
      end
      if (cap_rd[k] && old[s] > 0) void'(mq[s].pop_front());
      if (frame_stb && stream_en[s] && v && old[s] < DEPTH) mq[s].push_back(d);
    end
    exp_mid = exp_mid & ~clr_mid;
    exp_xtr = exp_xtr & ~clr_xtr;
    for (int s = 0; s < 6; s++) begin
      nw = mq[s].size();
      if (nw != old[s]) begin
        if (nw == DEPTH / 2 || nw == DEPTH) exp_mid[s] = 1'b1;
        if (nw == 0 || nw == DEPTH) exp_xtr[s] = 1'b1;
      end
    end
  endtask

  task automatic compare();
    chk(out_tag == exp_tag, "R5 tag", 240'(out_tag), 240'(exp_tag));
    chk(out_slots[lo(3) +: 40] == exp_slots[lo(3) +: 40], "R1 slots3-4",
        240'(out_slots[lo(3) +: 40]), 240'(exp_slots[lo(3) +: 40]));
    chk(out_slots[lo(5) +: 20] == exp_slots[lo(5) +: 20], "R2 slot5",
        240'(out_slots[lo(5) +: 20]), 240'(exp_slots[lo(5) +: 20]));
    chk(out_slots[lo(6) +: 20] == exp_slots[lo(6) +: 20] &&
        out_slots[lo(11) +: 20] == exp_slots[lo(11) +: 20], "R3 slot6/11",
        {out_slots[lo(6) +: 20], out_slots[lo(11) +: 20]},
        {exp_slots[lo(6) +: 20], exp_slots[lo(11) +: 20]});
    chk(out_slots == exp_slots, "R4 frame", out_slots, exp_slots);
    for (int k = 0; k < 3; k++) begin
      chk(pb_full[k] == (mq[2 * k].size() == DEPTH), "R8 pb_full",
          240'(pb_full[k]), 240'(mq[2 * k].size() == DEPTH));
      chk(cap_avail[k] == (mq[2 * k + 1].size() > 0), "R8 cap_avail",
          240'(cap_avail[k]), 240'(mq[2 * k + 1].size() > 0));
    end
    if (mq[1].size() > 0) chk(cap0_rdata == mq[1][0], "R6 cap0", 240'(cap0_rdata), 240'(mq[1][0]));
    if (mq[3].size() > 0) chk(cap1_rdata == mq[3][0][15:0], "R7 cap1", 240'(cap1_rdata), 240'(mq[3][0][15:0]));
    if (mq[5].size() > 0) chk(cap2_rdata == mq[5][0][15:0], "R7 cap2", 240'(cap2_rdata), 240'(mq[5][0][15:0]));
    chk(mid_flags == exp_mid, "R9 R11 mid_flags", 240'(mid_flags), 240'(exp_mid));
    chk(xtr_flags == exp_xtr, "R10 R11 xtr_flags", 240'(xtr_flags), 240'(exp_xtr));
    chk(smi == |(exp_mid & smi_en), "R9 smi", 240'(smi), 240'(|(exp_mid & smi_en)));
  endtask

  // one phase of biased random traffic
  task automatic run(input int n, input int p_wr, input int p_rd, input int p_fr,
                     input logic [5:0] en, input int p_clr);
    stream_en = en;
    smi_en = 6'($urandom);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 3; k++) begin
        pb_wr[k]  = ($urandom % 100) < p_wr;
        cap_rd[k] = ($urandom % 100) < p_rd;
      end
      pb0_wdata = $urandom; pb1_wdata = 16'($urandom); pb2_wdata = 16'($urandom);
      frame_stb = ($urandom % 100) < p_fr;
      in_tag = 16'($urandom) | 16'($urandom);
      for (int j = 0; j < 8; j++) in_slots[j * 30 +: 30] = 30'($urandom);
      for (int s = 0; s < 6; s++) begin
        clr_mid[s] = ($urandom % 100) < p_clr;
        clr_xtr[s] = ($urandom % 100) < p_clr;
      end
      if (($urandom % 50) == 0) pb_sel11 = ~pb_sel11;
      if (($urandom % 50) == 0) cap_sel11 = ~cap_sel11;
      tick();
      @(negedge clk);
      compare();
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state: R4 R8 R11
    compare();
    // writes only, no frames: buffers fill and saturate (R8 drop)
    run(40, 80, 0, 0, 6'h3f, 0);
    // all streams, slot 6, normal rate
    pb_sel11 = 1'b0; cap_sel11 = 1'b0;
    run(1500, 45, 45, 33, 6'h3f, 3);
    // disabled streams keep zero slots and accept nothing (R4 R6 R7)
    run(600, 50, 40, 40, 6'b010101, 3);
    run(600, 50, 40, 40, 6'b101010, 3);
    // dense clears collide with set events (R11)
    run(1500, 50, 50, 33, 6'h3f, 50);
    // drain everything: empty events (R10)
    run(300, 0, 90, 60, 6'h3f, 0);
    run(1500, 60, 30, 25, 6'h3f, 10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule